// File: doc/BRIEF.md
# Two-Level Translation Table Walker

When a translation lookaside buffer misses, this block fetches the mapping for the missing virtual address from a two-level table held in memory. It takes one miss at a time. It forms the first-level descriptor address from a programmable table base and the top twelve bits of the virtual address, then issues a read on a single-outstanding memory port. The descriptor it gets back does one of three things: it maps a 1 MB section or 16 MB supersection directly, it points to a coarse second-level table, or it is invalid.

For a coarse pointer the walker makes a second read, indexed by virtual address bits 19:12. That descriptor maps a 4 KB small page or a 64 KB large page, or it is invalid. The result holds the physical address, the page size, three memory attributes (endianness, element size and a mixed-size flag) and the virtual address. On an invalid descriptor the result is a translation fault instead. Large pages and supersections are stored in the table as sixteen identical copies. As a result, any copy the walker lands on decodes to the same mapping.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `miss_ready` is 1, `rd_req_valid` is 0 and `res_valid` is 0.
- R2: A base write keeps bits 31:7 of `base_wdata` and clears bits 6:0. The first read address is (cleared base) + VA[31:20]*4.
- R3: A first-level descriptor with bits 1:0 = 2 and bit 18 = 0 ends the walk with size code 2 (1 MB). The physical address is {D[31:20], VA[19:0]}, endianness is D[15], element size is D[11:10] and mixed is D[17].
- R4: A first-level descriptor with bits 1:0 = 2 and bit 18 = 1 ends the walk with size code 3 (16 MB). The physical address is {D[31:24], VA[23:0]}, and the attributes are taken as in R3.
- R5: A first-level descriptor with bits 1:0 = 1 causes a second read at {D[31:10], VA[19:12], 2'b00}.
- R6: A second-level descriptor with bits 1:0 = 2 gives size code 0 (4 KB) and physical address {D[31:12], VA[11:0]}. Endianness is D[9], element size is D[5:4] and mixed is D[11].
- R7: A second-level descriptor with bits 1:0 = 1 gives size code 1 (64 KB) and physical address {D[31:16], VA[15:0]}, with the attributes taken as in R6.
- R8: Type bits 0 or 3 at either level give `res_fault` = 1 with `res_va` equal to the missed address. The physical address, size and attributes are all 0, and no further read is issued.
- R9: Only one walk is in flight at a time. `miss_ready` is low from acceptance until the result is taken. A read request holds its address until `rd_req_ready`, and a result holds until `res_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Write strobe for the table base |
| base_wdata | input | 32 | Table base value |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker can accept a miss |
| miss_va | input | 32 | Virtual address that missed |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Descriptor byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Walk result valid |
| res_ready | input | 1 | Result consumer ready |
| res_fault | output | 1 | Translation fault |
| res_va | output | 32 | Virtual address of the walk |
| res_pa | output | 32 | Translated physical address |
| res_size | output | 2 | 0=4 KB, 1=64 KB, 2=1 MB, 3=16 MB |
| res_endian | output | 1 | Endianness attribute |
| res_elsize | output | 2 | Element size attribute |
| res_mixed | output | 1 | Mixed-size attribute |

## Verification
The assertions check the properties that hold on every cycle:
- word alignment of every read address;
- a stalled read or result holding steady;
- no read or result while the walker is idle;
- zeroed fault payloads;
- the section and supersection results keeping the untranslated offset bits of the virtual address.

The field positions, descriptor-type choices and second-level address formation can only be shown by the bench's sweep. That sweep covers every pair of first- and second-level type codes with both values of the supersection flag, varied bases and varied handshake stalls.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        miss_valid,
  output logic        miss_ready,
  input  logic [31:0] miss_va,
  output logic        rd_req_valid,
  input  logic        rd_req_ready,
  output logic [31:0] rd_addr,
  input  logic        rd_rsp_valid,
  input  logic [31:0] rd_rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_fault,
  output logic [31:0] res_va,
  output logic [31:0] res_pa,
  output logic [1:0]  res_size,
  output logic        res_endian,
  output logic [1:0]  res_elsize,
  output logic        res_mixed
);

  typedef enum logic [2:0] {IDLE, L1_REQ, L1_WAIT, L2_REQ, L2_WAIT, DONE} state_t;

  state_t      state;
  logic [31:0] base_q, va_q;
  logic [21:0] coarse_q;

  logic        d_fault, d_coarse, d_endian, d_mixed;
  logic [31:0] d_pa;
  logic [1:0]  d_size, d_elsize;
  wire  [31:0] d = rd_rsp_data;

  assign miss_ready   = (state == IDLE);
  assign rd_req_valid = (state == L1_REQ) || (state == L2_REQ);
  assign res_valid    = (state == DONE);
  assign res_va       = va_q;
  assign rd_addr      = (state == L2_REQ) ? {coarse_q, va_q[19:12], 2'b00}
                                          : base_q + {18'd0, va_q[31:20], 2'b00};

  always_comb begin
    d_fault = 1'b1; d_coarse = 1'b0; d_pa = '0; d_size = '0;
    d_endian = 1'b0; d_elsize = '0; d_mixed = 1'b0;
    if (state == L1_WAIT) begin
      if (d[1:0] == 2'd2) begin
        d_fault  = 1'b0;
        d_endian = d[15]; d_elsize = d[11:10]; d_mixed = d[17];
        if (d[18]) begin d_size = 2'd3; d_pa = {d[31:24], va_q[23:0]}; end
        else       begin d_size = 2'd2; d_pa = {d[31:20], va_q[19:0]}; end
      end else if (d[1:0] == 2'd1) begin
        d_fault = 1'b0; d_coarse = 1'b1;
      end
    end else if (state == L2_WAIT) begin
      if (d[1:0] != 2'd0 && d[1:0] != 2'd3) begin
        d_fault  = 1'b0;
        d_endian = d[9]; d_elsize = d[5:4]; d_mixed = d[11];
        if (d[1:0] == 2'd2) begin d_size = 2'd0; d_pa = {d[31:12], va_q[11:0]}; end
        else                begin d_size = 2'd1; d_pa = {d[31:16], va_q[15:0]}; end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; base_q <= '0; va_q <= '0; coarse_q <= '0;
      res_fault <= 1'b0; res_pa <= '0; res_size <= '0;
      res_endian <= 1'b0; res_elsize <= '0; res_mixed <= 1'b0;
    end else begin
      if (base_we) base_q <= {base_wdata[31:7], 7'd0};
      case (state)
        IDLE:    if (miss_valid) begin va_q <= miss_va; state <= L1_REQ; end
        L1_REQ:  if (rd_req_ready) state <= L1_WAIT;
        L2_REQ:  if (rd_req_ready) state <= L2_WAIT;
        L1_WAIT, L2_WAIT:
          if (rd_rsp_valid) begin
            if (d_coarse) begin
              coarse_q <= d[31:10];
              state    <= L2_REQ;
            end else begin
              res_fault  <= d_fault;  res_pa     <= d_pa;   res_size  <= d_size;
              res_endian <= d_endian; res_elsize <= d_elsize; res_mixed <= d_mixed;
              state      <= DONE;
            end
          end
        DONE:    if (res_ready) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  AST_RD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_addr[1:0] == 2'b00); // R2
  AST_SECTION_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && res_size == 2'd2 |-> res_pa[19:0] == res_va[19:0]); // R3
  AST_SUPER_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault && res_size == 2'd3 |-> res_pa[23:0] == res_va[23:0]); // R4
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_pa == 32'd0 && res_size == 2'd0 && !res_endian && !res_mixed); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !rd_req_valid && !res_valid); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !base_we |=> rd_req_valid && $stable(rd_addr)); // R9
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_pa) && $stable(res_fault) && $stable(res_size)); // R9

endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic base_we = 0, miss_valid = 0, rd_req_ready = 0, rd_rsp_valid = 0, res_ready = 0;
  logic [31:0] base_wdata = 0, miss_va = 0, rd_rsp_data = 0;
  logic miss_ready, rd_req_valid, res_valid, res_fault, res_endian, res_mixed;
  logic [31:0] rd_addr, res_va, res_pa;
  logic [1:0] res_size, res_elsize;
  int checks = 0, fails = 0, stall = 0;

  always #2 clk = ~clk;

  pt_walker dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic serve(input logic [31:0] exp_addr, input logic [31:0] data, input string req);
    logic [31:0] first;
    while (!rd_req_valid) @(negedge clk);
    first = rd_addr;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(rd_req_valid && rd_addr == first, "R9 read held", rd_addr, first);
    end
    chk(rd_addr == exp_addr, req, rd_addr, exp_addr);
    rd_req_ready = 1; @(negedge clk); rd_req_ready = 0;
    for (int k = 0; k < stall; k++) @(negedge clk);
    rd_rsp_valid = 1; rd_rsp_data = data; @(negedge clk); rd_rsp_valid = 0;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] d1, input logic [31:0] d2,
                      input logic [31:0] basew);
    logic f; logic [31:0] pa; logic [1:0] sz, el; logic en, mx; string req;
    f = 1; pa = 0; sz = 0; el = 0; en = 0; mx = 0; req = "R8 fault";
    if (d1[1:0] == 2) begin
      f = 0; en = d1[15]; el = d1[11:10]; mx = d1[17];
      if (d1[18]) begin sz = 3; pa = {d1[31:24], va[23:0]}; req = "R4 supersection"; end
      else        begin sz = 2; pa = {d1[31:20], va[19:0]}; req = "R3 section"; end
    end else if (d1[1:0] == 1 && (d2[1:0] == 1 || d2[1:0] == 2)) begin
      f = 0; en = d2[9]; el = d2[5:4]; mx = d2[11];
      if (d2[1:0] == 2) begin sz = 0; pa = {d2[31:12], va[11:0]}; req = "R6 small page"; end
      else              begin sz = 1; pa = {d2[31:16], va[15:0]}; req = "R7 large page"; end
    end
    @(negedge clk); base_we = 1; base_wdata = basew;
    @(negedge clk); base_we = 0; miss_valid = 1; miss_va = va;
    @(negedge clk); miss_valid = 0;
    chk(!miss_ready, "R9 busy", {31'd0, miss_ready}, 0);
    serve((basew & ~32'h7F) + {18'd0, va[31:20], 2'b00}, d1, "R2 first read address");
    if (d1[1:0] == 1) serve({d1[31:10], va[19:12], 2'b00}, d2, "R5 second read address");
    while (!res_valid) begin
      chk(!rd_req_valid, "R8 no extra read", {31'd0, rd_req_valid}, 0);
      @(negedge clk);
    end
    chk(res_fault == f, req, {31'd0, res_fault}, {31'd0, f});
    chk(res_pa == pa, req, res_pa, pa);
    chk(res_va == va, req, res_va, va);
    chk({res_size, res_elsize, res_endian, res_mixed} == {sz, el, en, mx}, req,
        {26'd0, res_size, res_elsize, res_endian, res_mixed}, {26'd0, sz, el, en, mx});
    @(negedge clk);
    chk(res_valid && res_pa == pa, "R9 result held", res_pa, pa);
    res_ready = 1; @(negedge clk); res_ready = 0;
    chk(miss_ready, "R9 idle after take", {31'd0, miss_ready}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(miss_ready && !rd_req_valid && !res_valid, "R1 reset state",
        {29'd0, miss_ready, rd_req_valid, res_valid}, 32'h4);
    for (int n = 0; n < 128; n++) begin
      logic [31:0] va, d1, d2, bw;
      stall = n % 3;
      va = 32'h9ABC_DEF1 * (n + 1);
      d1 = 32'h5A3C_96E1 * (n + 3);
      d2 = 32'hC3A5_1F27 * (n + 5);
      d1[1:0] = n[6:5]; d1[18] = n[4]; d2[1:0] = n[3:2];
      bw = (32'h0123_4000 * (n[1:0] + 1)) | {25'd0, n[6:0] | 7'h41};
      walk(va, d1, d2, bw);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule